// File: doc/BRIEF.md
# EDO DRAM Page-Mode Controller

This block sits between a synchronous on-chip requester and an asynchronous EDO DRAM with a 10-bit multiplexed address bus and an 8-bit data bus. The requester hands over one access at a time through a valid/ready pair: a 20-bit word address, a write flag and, for writes, a byte. The controller divides the address into a row (upper ten bits) and a column (lower ten bits). It drives the active-low row strobe, column strobe, write enable and output enable, and it produces every minimum interval by counting clock cycles. The integrator sets each count as a parameter by rounding the nanosecond figure up.

After an access the row stays open. A later request to the same row needs only a new column strobe pulse. A request to another row first closes the row, waits out the precharge time and then opens the new row. A separate refresh scheduler raises a level request. At the next access boundary the controller closes any open row, runs a refresh in which CAS falls before RAS, and returns a one-cycle grant. The controller also closes the row on its own before the row strobe has been low for the longest time allowed.

Top module: `edo_page_ctrl`

## Requirements
- R1: After a synchronous active-low reset all four strobes are high, the data driver is off, `rd_valid` and `ref_gnt` are low and `req_ready` is high when no refresh is pending.
- R2: The row strobe falls while `dram_addr` holds address bits [19:10]. The column strobe falls while it holds bits [9:0].
- R3: At least `T_RCD` cycles separate the row strobe falling from the first column strobe falling that follows it.
- R4: Each low pulse of the row strobe lasts at least `T_RAS` cycles.
- R5: The row strobe stays high for at least `T_RP` cycles before it falls again.
- R6: Each column strobe low pulse lasts at least `T_CAS` cycles. Between page accesses the column strobe stays high for at least `T_CP` cycles.
- R7: A write is an early write. Write enable is low and the data driver is on with the write byte at least one cycle before the column strobe falls, and both hold until the strobe rises.
- R8: A read returns the byte stored at its address on `rd_data`, marked by a one-cycle `rd_valid` pulse in the cycle after the column strobe rises.
- R9: A request whose row equals the open row is served with a column strobe pulse alone, with no new row strobe fall.
- R10: A request to a different row closes the open row, precharges and opens the new row exactly once before its column access.
- R11: A refresh lowers the column strobe before the row strobe and then raises both together. Address and data play no part in it, and one single-cycle `ref_gnt` pulse ends it.
- R12: The row strobe never stays low for more than `T_RAS_MAX` cycles. An idle open row is closed before that bound is reached.
- R13: A refresh request that is pending while a row is open wins over a new request. The request is accepted only after the grant, and it reopens its row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted on this cycle when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in [19:10], column in [9:0] |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| rd_data | output | 8 | Byte returned by a read |
| ref_req | input | 1 | Level refresh request from the scheduler |
| ref_gnt | output | 1 | One-cycle pulse when a refresh has finished |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 8 | Data toward the memory |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 8 | Data from the memory |

## Verification
A pending refresh and a page-hit request can both reach the open-row state in the same cycle. The bench arranges this by raising `ref_req` on the same cycle as a read whose row matches the open row. A small DRAM model in the bench records that the refresh happened before the access was accepted, that the row was opened again and that the read data is correct. The row lifetime limit can likewise coincide with a waiting request. The bench judges that case by the longest row strobe low interval it sees on the pins.

// File: rtl/edo_pkg.sv
// Package: shared state encoding for the EDO page-mode controller.
// Assumes: nothing beyond SystemVerilog 2017.
package edo_pkg;

    typedef enum logic [3:0] {
        ST_CLOSED,  // row strobe high, precharge complete
        ST_ACT,     // drive row strobe low
        ST_RCD,     // wait row-to-column delay
        ST_COL,     // drive column strobe low
        ST_CASL,    // hold column strobe low
        ST_CASH,    // hold column strobe high (page precharge)
        ST_OPEN,    // row open, waiting at an access boundary
        ST_PRE,     // row precharge
        ST_CBR_C,   // refresh: column strobe low first
        ST_CBR_R    // refresh: row strobe low
    } ctrl_state_t;

endpackage

// File: rtl/edo_ival_timer.sv
// Module: loadable down-counter that measures one strobe interval.
// A load of N (N >= 1) raises done on the N-th clock edge after the load edge,
// so a strobe changed at the load edge is held exactly N cycles.
// Assumes: load value is never zero.
module edo_ival_timer #(
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);

    logic [TW-1:0] cnt_q;

    // Count down from the loaded interval and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - TW'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/edo_row_age.sv
// Module: counts the clock edges the row strobe has been low for.
// The count clears while the strobe is high and saturates at its top value.
// Assumes: ras_n is the registered strobe as it leaves the controller.
module edo_row_age #(
    parameter int LIMIT = 20000,
    localparam int AGW  = $clog2(LIMIT + 2)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ras_n,
    output logic [AGW-1:0] age
);

    localparam logic [AGW-1:0] AGE_TOP = '1;

    // Track the age of the low phase of the row strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || ras_n) begin
            age <= '0;
        end else if (age != AGE_TOP) begin
            age <= age + AGW'(1);
        end
    end

endmodule

// File: rtl/edo_page_ctrl.sv
// Module: EDO DRAM page-mode controller (top).
// Accepts one access at a time, keeps the row open for page hits, closes it on
// a miss, a pending refresh or the row-lifetime bound, and runs CAS-first
// refresh cycles. All intervals are clock-cycle counts given as parameters.
// Assumes: every T_* >= 1, T_RAS_MAX > T_RAS + T_CAS + T_CP + 3,
// and the memory row and column widths are both MA_W.
module edo_page_ctrl #(
    parameter int MA_W      = 10,
    parameter int DW        = 8,
    parameter int T_RP      = 8,
    parameter int T_RCD     = 4,
    parameter int T_CAS     = 2,
    parameter int T_CP      = 2,
    parameter int T_RAS     = 12,
    parameter int T_RAS_MAX = 20000,
    localparam int AW       = 2 * MA_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_we,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    output logic            rd_valid,
    output logic [DW-1:0]   rd_data,
    input  logic            ref_req,
    output logic            ref_gnt,
    output logic            dram_ras_n,
    output logic            dram_cas_n,
    output logic            dram_we_n,
    output logic            dram_oe_n,
    output logic [MA_W-1:0] dram_addr,
    output logic [DW-1:0]   dram_dq_out,
    output logic            dram_dq_oe,
    input  logic [DW-1:0]   dram_dq_in
);
    import edo_pkg::*;

    localparam int TW       = $clog2(T_RP + T_RCD + T_CAS + T_CP + T_RAS + 1);
    localparam int AGW      = $clog2(T_RAS_MAX + 2);
    localparam int SPAN     = T_CAS + T_CP + 3;
    localparam int AGE_STOP = T_RAS_MAX - SPAN;

    ctrl_state_t    st_q, st_d;
    logic           ras_q, ras_d, cas_q, cas_d, we_q, we_d, oe_q, oe_d;
    logic [MA_W-1:0] addr_q, addr_d, row_q, row_d, pcol_q, pcol_d;
    logic [DW-1:0]  dqo_q, dqo_d, pdat_q, pdat_d, rdd_q, rdd_d;
    logic           dqoe_q, dqoe_d, pwe_q, pwe_d, rdv_q, rdv_d, gnt_q, gnt_d;
    logic           t_load, t_done;
    logic [TW-1:0]  t_val;
    logic [AGW-1:0] age;
    logic           min_met, near_limit, row_hit;

    edo_ival_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done)
    );

    edo_row_age #(.LIMIT(T_RAS_MAX)) u_age (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_q), .age(age)
    );

    // Row may close at this edge / must not start another page access.
    assign min_met    = (int'(age) >= T_RAS - 1);
    assign near_limit = (int'(age) >= AGE_STOP);
    assign row_hit    = (req_addr[AW-1:MA_W] == row_q);

    // Next-state and next-strobe decision for every phase of an access.
    always_comb begin
        st_d = st_q;   ras_d = ras_q;   cas_d = cas_q;   we_d = we_q;
        oe_d = oe_q;   addr_d = addr_q; row_d = row_q;   pcol_d = pcol_q;
        dqo_d = dqo_q; dqoe_d = dqoe_q; pdat_d = pdat_q; pwe_d = pwe_q;
        rdd_d = rdd_q; rdv_d = 1'b0;    gnt_d = 1'b0;
        t_load = 1'b0; t_val = '0;      req_ready = 1'b0;
        unique case (st_q)
            ST_CLOSED: begin
                if (ref_req) begin
                    cas_d = 1'b0; t_load = 1'b1; t_val = TW'(T_CP); st_d = ST_CBR_C;
                end else begin
                    req_ready = 1'b1;
                    if (req_valid) begin
                        addr_d = req_addr[AW-1:MA_W]; row_d = req_addr[AW-1:MA_W];
                        pcol_d = req_addr[MA_W-1:0];  pwe_d = req_we;
                        pdat_d = req_wdata;           st_d  = ST_ACT;
                    end
                end
            end
            ST_ACT: begin
                ras_d = 1'b0; t_load = 1'b1; t_val = TW'(T_RCD); st_d = ST_RCD;
            end
            ST_RCD: if (t_done) begin
                addr_d = pcol_q; we_d = !pwe_q; oe_d = pwe_q;
                dqo_d = pdat_q;  dqoe_d = pwe_q; st_d = ST_COL;
            end
            ST_COL: begin
                cas_d = 1'b0; t_load = 1'b1; t_val = TW'(T_CAS); st_d = ST_CASL;
            end
            ST_CASL: if (t_done) begin
                cas_d = 1'b1; we_d = 1'b1; oe_d = 1'b1; dqoe_d = 1'b0;
                if (!pwe_q) begin rdv_d = 1'b1; rdd_d = dram_dq_in; end
                t_load = 1'b1; t_val = TW'(T_CP); st_d = ST_CASH;
            end
            ST_CASH: if (t_done) st_d = ST_OPEN;
            ST_OPEN: begin
                if (ref_req || near_limit || (req_valid && !row_hit)) begin
                    if (min_met) begin
                        ras_d = 1'b1; t_load = 1'b1; t_val = TW'(T_RP); st_d = ST_PRE;
                    end
                end else begin
                    req_ready = 1'b1;
                    if (req_valid) begin
                        pwe_d = req_we; pdat_d = req_wdata;
                        addr_d = req_addr[MA_W-1:0]; we_d = !req_we; oe_d = req_we;
                        dqo_d = req_wdata; dqoe_d = req_we; st_d = ST_COL;
                    end
                end
            end
            ST_PRE: if (t_done) st_d = ST_CLOSED;
            ST_CBR_C: if (t_done) begin
                ras_d = 1'b0; t_load = 1'b1; t_val = TW'(T_RAS); st_d = ST_CBR_R;
            end
            ST_CBR_R: if (t_done) begin
                ras_d = 1'b1; cas_d = 1'b1; gnt_d = 1'b1;
                t_load = 1'b1; t_val = TW'(T_RP); st_d = ST_PRE;
            end
            default: st_d = ST_CLOSED;
        endcase
    end

    // Register the state, strobes, bus values and host-side outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_CLOSED; ras_q <= 1'b1; cas_q <= 1'b1; we_q <= 1'b1; oe_q <= 1'b1;
            addr_q <= '0; row_q <= '0; pcol_q <= '0; dqo_q <= '0; dqoe_q <= 1'b0;
            pdat_q <= '0; pwe_q <= 1'b0; rdd_q <= '0; rdv_q <= 1'b0; gnt_q <= 1'b0;
        end else begin
            st_q <= st_d; ras_q <= ras_d; cas_q <= cas_d; we_q <= we_d; oe_q <= oe_d;
            addr_q <= addr_d; row_q <= row_d; pcol_q <= pcol_d; dqo_q <= dqo_d;
            dqoe_q <= dqoe_d; pdat_q <= pdat_d; pwe_q <= pwe_d; rdd_q <= rdd_d;
            rdv_q <= rdv_d; gnt_q <= gnt_d;
        end
    end

    assign dram_ras_n  = ras_q;
    assign dram_cas_n  = cas_q;
    assign dram_we_n   = we_q;
    assign dram_oe_n   = oe_q;
    assign dram_addr   = addr_q;
    assign dram_dq_out = dqo_q;
    assign dram_dq_oe  = dqoe_q;
    assign rd_valid    = rdv_q;
    assign rd_data     = rdd_q;
    assign ref_gnt     = gnt_q;

    // R3: a column strobe fall inside a row cycle comes T_RCD or more edges after the row fall.
    p_rcd_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_ras_n) |-> (int'(age) >= T_RCD));

    // R4: the row strobe low pulse just ended lasted at least T_RAS cycles.
    p_ras_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> (int'(age) >= T_RAS));

    // R12: the row strobe low interval stays below the lifetime bound.
    p_ras_max_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_ras_n |-> (int'(age) < T_RAS_MAX));

    // R7: a write column strobe fall finds WE already low and the driver on.
    p_early_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_we_n) |-> ($past(!dram_we_n) && dram_dq_oe));

    // R11: when the row strobe falls with CAS low, CAS was already low before.
    p_cbr_order_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && !dram_cas_n) |-> $past(!dram_cas_n));

    // R11: the refresh grant is a single-cycle pulse.
    p_gnt_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ref_gnt |=> !ref_gnt);

    // R8: read data is flagged only as the column strobe returns high.
    p_rdv_at_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $rose(dram_cas_n));

endmodule

// File: tb/edo_page_ctrl_tb.sv
module edo_page_ctrl_tb;

    localparam int P_RP = 4, P_RCD = 3, P_CAS = 2, P_CP = 2, P_RAS = 10, P_RMAX = 200;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0, ref_req = 1'b0;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_wdata = '0, dq_in = '0;
    logic        req_ready, rd_valid, ref_gnt, ras_n, cas_n, we_n, oe_n, dq_oe;
    logic [7:0]  rd_data, dq_out;
    logic [9:0]  maddr;

    always #2.5 clk = ~clk;

    edo_page_ctrl #(.T_RP(P_RP), .T_RCD(P_RCD), .T_CAS(P_CAS), .T_CP(P_CP),
                    .T_RAS(P_RAS), .T_RAS_MAX(P_RMAX)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_gnt(ref_gnt),
        .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
        .dram_addr(maddr), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

    int total = 0, bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // DRAM model and pin-timing monitor, sampled on the falling clock edge.
    logic [7:0] mem [int];
    logic [9:0] m_row = '0, m_col = '0;
    int act_cnt = 0, cbr_cnt = 0, rd_seen = 0, ras_lo_max = 0;
    int ras_cnt = 100, cas_cnt = 100;
    logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, gnt_seen = 1'b0, mon_on = 1'b0;
    logic [7:0] rd_last = '0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (p_cas && !cas_n) begin
                if (!ras_n) begin
                    chk(ras_cnt >= P_RCD, "R3 ras-to-cas", ras_cnt, P_RCD);
                    m_col = maddr; if (!we_n) mem[int'({m_row, m_col})] = dq_out;
                    else dq_in <= mem.exists(int'({m_row, m_col})) ? mem[int'({m_row, m_col})] : 8'h00;
                    chk(cas_cnt >= P_CP, "R6 cas high", cas_cnt, P_CP);
                    if (!we_n) chk(!p_we && dq_oe, "R7 early write", {p_we, dq_oe}, 1);
                end
            end
            if (!p_cas && cas_n) chk(cas_cnt >= P_CAS, "R6 cas low", cas_cnt, P_CAS);
            if (p_ras && !ras_n) begin
                chk(ras_cnt >= P_RP, "R5 precharge", ras_cnt, P_RP);
                if (cas_n) begin m_row = maddr; act_cnt++; end else cbr_cnt++;
            end
            if (!p_ras && ras_n) begin
                chk(ras_cnt >= P_RAS, "R4 ras low min", ras_cnt, P_RAS);
                if (ras_cnt > ras_lo_max) ras_lo_max = ras_cnt;
            end
            if (rd_valid) begin rd_seen++; rd_last = rd_data; end
            if (ref_gnt) begin gnt_seen = 1'b1; ref_req = 1'b0; end
        end
        ras_cnt = (p_ras != ras_n) ? 1 : ras_cnt + 1;
        cas_cnt = (p_cas != cas_n) ? 1 : cas_cnt + 1;
        p_ras = ras_n; p_cas = cas_n; p_we = we_n;
    end

    // Present one request and hold it until the controller takes it.
    task automatic issue(input bit we, input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    typedef struct packed {
        logic        we;
        logic [19:0] addr;
        logic [7:0]  data;
        logic        act;   // expected new row activations
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{1'b1, 20'h12345, 8'hA5, 1'b1},   // R10 first open
        '{1'b1, 20'h12346, 8'h3C, 1'b0},   // R9 page write
        '{1'b0, 20'h12345, 8'hA5, 1'b0},   // R9 page read
        '{1'b1, 20'h54321, 8'h7E, 1'b1},   // R10 miss
        '{1'b0, 20'h12346, 8'h3C, 1'b1},   // R10 miss back
        '{1'b0, 20'h54321, 8'h7E, 1'b1},
        '{1'b0, 20'h54321, 8'h7E, 1'b0},   // R9 repeated read
        '{1'b1, 20'h543FF, 8'h81, 1'b0},   // R2 top column
        '{1'b0, 20'h543FF, 8'h81, 1'b0}
    };

    int wd = 0;
    bit finished = 1'b0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000 && !finished) begin
            finished = 1'b1;
            chk(1'b0, "watchdog", wd, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int a0, r0, c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        chk(ras_n && cas_n && we_n && oe_n, "R1 strobes", {ras_n, cas_n, we_n, oe_n}, 4'hF);
        chk(!dq_oe && !rd_valid && !ref_gnt, "R1 outputs", {dq_oe, rd_valid, ref_gnt}, 0);
        chk(req_ready, "R1 ready", req_ready, 1);
        mon_on = 1'b1;

        foreach (VECS[i]) begin
            a0 = act_cnt; r0 = rd_seen;
            issue(VECS[i].we, VECS[i].addr, VECS[i].data);
            repeat (15) @(negedge clk);
            chk(act_cnt - a0 == int'(VECS[i].act), "R9/R10 activations", act_cnt - a0, VECS[i].act);
            chk({m_row, m_col} == VECS[i].addr, "R2 row/col split", {m_row, m_col}, VECS[i].addr);
            if (!VECS[i].we) begin
                chk(rd_seen - r0 == 1, "R8 one rd_valid", rd_seen - r0, 1);
                chk(rd_last == VECS[i].data, "R8 read data", rd_last, VECS[i].data);
            end
        end

        // R11: refresh with a row open closes it and runs a CAS-first cycle.
        a0 = act_cnt; c0 = cbr_cnt; gnt_seen = 1'b0;
        @(negedge clk); ref_req = 1'b1;
        repeat (60) @(negedge clk);
        chk(gnt_seen, "R11 grant", gnt_seen, 1);
        chk(cbr_cnt - c0 == 1, "R11 one refresh", cbr_cnt - c0, 1);
        chk(act_cnt == a0, "R11 no row open", act_cnt - a0, 0);
        chk(ras_n && cas_n, "R11 strobes idle", {ras_n, cas_n}, 3);

        // R13: refresh and a page-hit request arrive together.
        issue(1'b0, 20'h54321, 8'h00);
        repeat (15) @(negedge clk);
        a0 = act_cnt; c0 = cbr_cnt; r0 = rd_seen; gnt_seen = 1'b0;
        @(negedge clk);
        ref_req = 1'b1; req_valid = 1'b1; req_we = 1'b0; req_addr = 20'h543FF;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        chk(gnt_seen && cbr_cnt - c0 == 1, "R13 refresh first", cbr_cnt - c0, 1);
        @(posedge clk); #1; req_valid = 1'b0;
        repeat (15) @(negedge clk);
        chk(act_cnt - a0 == 1, "R13 row reopened", act_cnt - a0, 1);
        chk(rd_seen - r0 == 1 && rd_last == 8'h81, "R13 read data", rd_last, 8'h81);

        // R12: an idle open row closes before the lifetime bound.
        repeat (P_RMAX + 30) @(negedge clk);
        chk(ras_n, "R12 row closed", ras_n, 1);
        chk(ras_lo_max <= P_RMAX && ras_lo_max > P_RMAX - 20, "R12 max low", ras_lo_max, P_RMAX);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule